// File: doc/BRIEF.md
# Network Controller Indirect Register Port

This block is the register front end of a network controller. A host reaches it through four 16-bit word locations on a small I/O bus. One location holds an index pointer. Two data windows use that pointer: one reaches the control/status register bank and the other reaches the bus-configuration register bank. A read of the fourth location soft-resets the controller. Every internal register is therefore reached in two steps: the host writes the index, then it accesses a window.

The block holds the main control/status word (CSR0), which mixes write-one command bits with read-only status bits. It also holds the two halves of the init-block address, a read-only pair of identification words and a bus-configuration mode word that selects 32-bit descriptors. Command bits leave the block as one-cycle pulses (init, start, transmit demand) for a separate engine. The engine reports back through a one-cycle init-done input. A soft-reset pulse is passed on to the engine as well.

Top module: `nic_regport`

## Requirements
- R1: The bus locations are at byte offsets 0x10 (control/status data window), 0x12 (index pointer), 0x14 (soft reset) and 0x16 (bus-configuration data window). A read of any other offset returns 0, and a write to any other offset changes nothing.
- R2: The index pointer holds the low PTR_W bits of the written value and reads them back unchanged, with the upper bits reading 0. It is cleared only by the hardware reset.
- R3: A read of offset 0x14 returns 0 and raises `eng_reset` for one cycle. After that read, CSR0 reads 0x0004, the init-block words and the mode word read 0, and the pointer is kept. The hardware reset leaves the same register state.
- R4: A write to CSR0 (index 0) with bit 0 set pulses `cmd_init`, with bit 1 set pulses `cmd_start`, and with bit 3 set pulses `cmd_tdmd`. Each pulse lasts one cycle and starts in the cycle after the write. These bits always read 0, and writing 0 to them has no effect.
- R5: CSR0 bit 2 (stopped) is set by reset and cleared when a start command is accepted. Writes cannot change it.
- R6: CSR0 bit 8 (init done) is set one cycle after `init_done_in` is high. A write of 1 to bit 8 clears it, and a write of 0 leaves it unchanged. If the set and the clear come in the same cycle, the set wins.
- R7: Control/status indices 1 and 2 are read/write words that hold the low and high halves of the init-block address. `ib_addr` outputs them as {index 2, index 1}.
- R8: Control/status indices 88 and 89 read the low and high halves of the 32-bit ID {4'h0, PART_CODE, VER_CODE} (0x1003 and 0x0262 by default). Writes to them are ignored.
- R9: Bus-configuration index 20 is a read/write mode word. `desc32` is high exactly when its low byte equals 2.
- R10: Every other index in either bank reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational while a read is strobed |
| init_done_in | input | 1 | Init-complete pulse from the engine |
| cmd_init | output | 1 | Init command pulse |
| cmd_start | output | 1 | Start command pulse |
| cmd_tdmd | output | 1 | Transmit-demand pulse |
| eng_reset | output | 1 | Soft-reset pulse to the engine |
| ib_addr | output | 32 | Init-block address |
| desc32 | output | 1 | 32-bit descriptor mode selected |

## Verification
The bench builds the block with its default parameters, ADDR_W = 5 and PTR_W = 7. With these values all 32 bus offsets and all 128 index values can be swept completely. Every index is read through both windows, before and after 0xFFFF is written to every location that has no effect, and the bench computes each expected word from the index. Directed sequences then cover each CSR0 command and status bit, the init-done set/clear collision, the mode decode and the soft reset.

// File: rtl/nic_regport_pkg.sv
package nic_regport_pkg;
  localparam int DW = 16;

  // bus byte offsets
  localparam int OFF_CDATA = 'h10;
  localparam int OFF_PTR   = 'h12;
  localparam int OFF_RST   = 'h14;
  localparam int OFF_BDATA = 'h16;

  // register indices
  localparam int IDX_CSR0  = 0;
  localparam int IDX_IBLO  = 1;
  localparam int IDX_IBHI  = 2;
  localparam int IDX_IDLO  = 88;
  localparam int IDX_IDHI  = 89;
  localparam int IDX_MODE  = 20;
  localparam int IB_WORDS  = 2;

  // CSR0 bit positions
  localparam int B_INIT  = 0;
  localparam int B_START = 1;
  localparam int B_STOP  = 2;
  localparam int B_TDMD  = 3;
  localparam int B_IDON  = 8;

  localparam logic [7:0] MODE32_CODE = 8'd2;

  function automatic logic [DW-1:0] csr0_pack(input logic stop, input logic idon);
    logic [DW-1:0] v;
    v = '0;
    v[B_STOP] = stop;
    v[B_IDON] = idon;
    return v;
  endfunction

  function automatic logic [DW-1:0] id_half(input logic [15:0] part,
                                            input logic [11:0] ver,
                                            input logic hi);
    logic [31:0] w;
    w = {4'h0, part, ver};
    return hi ? w[31:16] : w[15:0];
  endfunction
endpackage

// File: rtl/nic_csr0_ctl.sv
module nic_csr0_ctl
  import nic_regport_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          wr_en,
  input  logic          w_init,
  input  logic          w_start,
  input  logic          w_tdmd,
  input  logic          w_idon,
  input  logic          init_done_in,
  output logic          cmd_init,
  output logic          cmd_start,
  output logic          cmd_tdmd,
  output logic [DW-1:0] csr0_view
);
  logic stop_q, idon_q;

  always_ff @(posedge clk) begin
    if (!rst_n || soft_rst) begin
      stop_q    <= 1'b1;
      idon_q    <= 1'b0;
      cmd_init  <= 1'b0;
      cmd_start <= 1'b0;
      cmd_tdmd  <= 1'b0;
    end else begin
      cmd_init  <= wr_en & w_init;
      cmd_start <= wr_en & w_start;
      cmd_tdmd  <= wr_en & w_tdmd;
      if (wr_en && w_start) stop_q <= 1'b0;
      if (init_done_in)            idon_q <= 1'b1;
      else if (wr_en && w_idon)    idon_q <= 1'b0;
    end
  end

  assign csr0_view = csr0_pack(stop_q, idon_q);
endmodule

// File: rtl/nic_cfg_regs.sv
module nic_cfg_regs
  import nic_regport_pkg::*;
#(
  parameter int PTR_W = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   soft_rst,
  input  logic                   ptr_we,
  input  logic                   csr_we,
  input  logic                   bcr_we,
  input  logic [DW-1:0]          wdata,
  output logic [PTR_W-1:0]       ptr_q,
  output logic [IB_WORDS*DW-1:0] ib_flat,
  output logic [DW-1:0]          mode_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_we) ptr_q <= wdata[PTR_W-1:0];
  end

  for (genvar g = 0; g < IB_WORDS; g++) begin : g_ib
    logic [DW-1:0] word_q;
    always_ff @(posedge clk) begin
      if (!rst_n || soft_rst) word_q <= '0;
      else if (csr_we && ptr_q == PTR_W'(IDX_IBLO + g)) word_q <= wdata;
    end
    assign ib_flat[g*DW +: DW] = word_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || soft_rst) mode_q <= '0;
    else if (bcr_we && ptr_q == PTR_W'(IDX_MODE)) mode_q <= wdata;
  end
endmodule

// File: rtl/nic_regport.sv
module nic_regport
  import nic_regport_pkg::*;
#(
  parameter int          ADDR_W    = 5,
  parameter int          PTR_W     = 7,
  parameter logic [15:0] PART_CODE = 16'h2621,
  parameter logic [11:0] VER_CODE  = 12'h003
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  input  logic              init_done_in,
  output logic              cmd_init,
  output logic              cmd_start,
  output logic              cmd_tdmd,
  output logic              eng_reset,
  output logic [31:0]       ib_addr,
  output logic              desc32
);
  localparam logic [ADDR_W-1:0] A_CDATA = ADDR_W'(OFF_CDATA);
  localparam logic [ADDR_W-1:0] A_PTR   = ADDR_W'(OFF_PTR);
  localparam logic [ADDR_W-1:0] A_RST   = ADDR_W'(OFF_RST);
  localparam logic [ADDR_W-1:0] A_BDATA = ADDR_W'(OFF_BDATA);

  // decoded bus events
  logic wr_cdata, rd_cdata, wr_ptr, rd_ptr, rd_rst, wr_bdata, rd_bdata;
  logic wr_c0;
  logic [PTR_W-1:0]       ptr_q;
  logic [15:0]            ptr_ext;
  logic [IB_WORDS*DW-1:0] ib_flat;
  logic [DW-1:0]          mode_q, csr0_view, csr_rd, bcr_rd;

  assign wr_cdata = bus_en &  bus_wr & (bus_addr == A_CDATA);
  assign rd_cdata = bus_en & ~bus_wr & (bus_addr == A_CDATA);
  assign wr_ptr   = bus_en &  bus_wr & (bus_addr == A_PTR);
  assign rd_ptr   = bus_en & ~bus_wr & (bus_addr == A_PTR);
  assign rd_rst   = bus_en & ~bus_wr & (bus_addr == A_RST);
  assign wr_bdata = bus_en &  bus_wr & (bus_addr == A_BDATA);
  assign rd_bdata = bus_en & ~bus_wr & (bus_addr == A_BDATA);
  assign wr_c0    = wr_cdata & (ptr_q == PTR_W'(IDX_CSR0));

  always_ff @(posedge clk) begin
    if (!rst_n) eng_reset <= 1'b0;
    else        eng_reset <= rd_rst;
  end

  nic_csr0_ctl u_csr0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .soft_rst     (rd_rst),
    .wr_en        (wr_c0),
    .w_init       (bus_wdata[B_INIT]),
    .w_start      (bus_wdata[B_START]),
    .w_tdmd       (bus_wdata[B_TDMD]),
    .w_idon       (bus_wdata[B_IDON]),
    .init_done_in (init_done_in),
    .cmd_init     (cmd_init),
    .cmd_start    (cmd_start),
    .cmd_tdmd     (cmd_tdmd),
    .csr0_view    (csr0_view)
  );

  nic_cfg_regs #(.PTR_W(PTR_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (rd_rst),
    .ptr_we   (wr_ptr),
    .csr_we   (wr_cdata),
    .bcr_we   (wr_bdata),
    .wdata    (bus_wdata),
    .ptr_q    (ptr_q),
    .ib_flat  (ib_flat),
    .mode_q   (mode_q)
  );

  assign ptr_ext = 16'(ptr_q);
  assign ib_addr = ib_flat;
  assign desc32  = (mode_q[7:0] == MODE32_CODE);

  always_comb begin
    csr_rd = '0;
    if      (ptr_q == PTR_W'(IDX_CSR0)) csr_rd = csr0_view;
    else if (ptr_q == PTR_W'(IDX_IBLO)) csr_rd = ib_flat[DW-1:0];
    else if (ptr_q == PTR_W'(IDX_IBHI)) csr_rd = ib_flat[2*DW-1:DW];
    else if (ptr_q == PTR_W'(IDX_IDLO)) csr_rd = id_half(PART_CODE, VER_CODE, 1'b0);
    else if (ptr_q == PTR_W'(IDX_IDHI)) csr_rd = id_half(PART_CODE, VER_CODE, 1'b1);
  end

  assign bcr_rd = (ptr_q == PTR_W'(IDX_MODE)) ? mode_q : '0;

  always_comb begin
    bus_rdata = '0;
    if (rd_cdata)      bus_rdata = csr_rd;
    else if (rd_ptr)   bus_rdata = ptr_ext;
    else if (rd_bdata) bus_rdata = bcr_rd;
  end
endmodule

// File: rtl/nic_regport_chk.sv
module nic_regport_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_cdata,
  input logic        rd_cdata,
  input logic        wr_ptr,
  input logic        rd_ptr,
  input logic        rd_rst,
  input logic        wr_bdata,
  input logic        rd_bdata,
  input logic        wr_c0,
  input logic [15:0] bus_wdata,
  input logic [15:0] ptr_ext,
  input logic [15:0] csr0_view,
  input logic        init_done_in,
  input logic        cmd_init,
  input logic        cmd_start,
  input logic        cmd_tdmd,
  input logic        eng_reset
);
  a_r1_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_cdata, rd_cdata, wr_ptr, rd_ptr, rd_rst, wr_bdata, rd_bdata}));

  a_r2_ptr_bits: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ptr |=> (ptr_ext & ~$past(bus_wdata)) == 16'h0);

  a_r2_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ptr |=> $stable(ptr_ext));

  a_r3_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rst |=> eng_reset && csr0_view == 16'h0004);

  a_r4_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_c0 && bus_wdata[1] && !rd_rst) |=> cmd_start);

  a_r4_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_c0 |=> !cmd_init && !cmd_start && !cmd_tdmd);

  a_r5_stop_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |-> !csr0_view[2]);

  a_r6_idon_set: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done_in && !rd_rst) |=> csr0_view[8]);
endmodule

bind nic_regport nic_regport_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_cdata     (wr_cdata),
  .rd_cdata     (rd_cdata),
  .wr_ptr       (wr_ptr),
  .rd_ptr       (rd_ptr),
  .rd_rst       (rd_rst),
  .wr_bdata     (wr_bdata),
  .rd_bdata     (rd_bdata),
  .wr_c0        (wr_c0),
  .bus_wdata    (bus_wdata),
  .ptr_ext      (ptr_ext),
  .csr0_view    (csr0_view),
  .init_done_in (init_done_in),
  .cmd_init     (cmd_init),
  .cmd_start    (cmd_start),
  .cmd_tdmd     (cmd_tdmd),
  .eng_reset    (eng_reset)
);

// File: tb/nic_regport_bench.sv
`timescale 1ns/1ps
module nic_regport_bench;
  localparam int PTR_W = 7;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_en = 0, bus_wr = 0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        init_done_in = 0;
  logic        cmd_init, cmd_start, cmd_tdmd, eng_reset, desc32;
  logic [31:0] ib_addr;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [15:0] rv;
  logic p_init, p_start, p_tdmd, p_rst;

  always #2 clk = ~clk;

  nic_regport u_nic_regport (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .init_done_in(init_done_in), .cmd_init(cmd_init), .cmd_start(cmd_start),
    .cmd_tdmd(cmd_tdmd), .eng_reset(eng_reset), .ib_addr(ib_addr), .desc32(desc32)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic [4:0] a, input logic [15:0] wd,
                     input logic idn = 1'b0);
    @(negedge clk);
    bus_en = 1; bus_wr = wr; bus_addr = a; bus_wdata = wd; init_done_in = idn;
    #1 rv = bus_rdata;
    @(posedge clk);
    #1;
    p_init = cmd_init; p_start = cmd_start; p_tdmd = cmd_tdmd; p_rst = eng_reset;
    bus_en = 0; init_done_in = 0;
  endtask

  function automatic logic [15:0] exp_csr_reset(input int idx);
    if (idx == 0)  return 16'h0004;
    if (idx == 88) return 16'h1003;
    if (idx == 89) return 16'h0262;
    return 16'h0;
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R3 reset state at the ports
    check("R3 reset cmds", {cmd_init, cmd_start, cmd_tdmd, eng_reset}, 0);
    check("R3 reset ib_addr", ib_addr, 0);
    check("R3 reset desc32", desc32, 0);

    // R1 sweep of all offsets (pointer is 0)
    for (int a = 0; a < 32; a++) begin
      acc(0, 5'(a), 0);
      check("R1 offset read", rv, (a == 'h10) ? 16'h0004 : 16'h0);
    end
    // R1 writes to other offsets ignored
    for (int a = 0; a < 32; a++)
      if (a != 'h10 && a != 'h12 && a != 'h16) acc(1, 5'(a), 16'hFFFF);
    acc(0, 5'h12, 0);
    check("R1 stray writes ptr", rv, 0);
    acc(0, 5'h10, 0);
    check("R1 stray writes csr0", rv, 16'h0004);
    check("R1 stray writes ib", ib_addr, 0);

    // R2/R8/R10 sweep of all indices after reset
    for (int i = 0; i < 128; i++) begin
      acc(1, 5'h12, 16'(i));
      acc(0, 5'h12, 0);
      check("R2 ptr readback", rv, i);
      acc(0, 5'h10, 0);
      check("R8/R10 csr window", rv, exp_csr_reset(i));
      acc(0, 5'h16, 0);
      check("R10 bcr window", rv, 0);
    end
    acc(1, 5'h12, 16'hFFFF);
    acc(0, 5'h12, 0);
    check("R2 upper bits zero", rv, 16'hFFFF & 16'((1 << PTR_W) - 1));

    // R10/R8 writes with no effect
    for (int i = 0; i < 128; i++) begin
      acc(1, 5'h12, 16'(i));
      if (i > 2) begin
        acc(1, 5'h10, 16'hFFFF);
        check("R10 no pulse", {p_init, p_start, p_tdmd}, 0);
      end
      if (i != 20) acc(1, 5'h16, 16'hFFFF);
    end
    for (int i = 0; i < 128; i++) begin
      acc(1, 5'h12, 16'(i));
      acc(0, 5'h10, 0);
      check("R8/R10 csr after writes", rv, exp_csr_reset(i));
      acc(0, 5'h16, 0);
      check("R10 bcr after writes", rv, 0);
    end
    check("R10 ib untouched", ib_addr, 0);
    check("R10 desc32 untouched", desc32, 0);

    // R7 init-block words
    acc(1, 5'h12, 1); acc(1, 5'h10, 16'h1234);
    acc(1, 5'h12, 2); acc(1, 5'h10, 16'hABCD);
    check("R7 ib_addr", ib_addr, 32'hABCD1234);
    acc(0, 5'h10, 0); check("R7 hi readback", rv, 16'hABCD);
    acc(1, 5'h12, 1); acc(0, 5'h10, 0); check("R7 lo readback", rv, 16'h1234);

    // R9 mode word
    acc(1, 5'h12, 20);
    acc(1, 5'h16, 16'h0002); check("R9 desc32 on", desc32, 1);
    acc(0, 5'h16, 0);        check("R9 mode readback", rv, 16'h0002);
    acc(1, 5'h16, 16'h0003); check("R9 desc32 off", desc32, 0);
    acc(1, 5'h16, 16'h5A02); check("R9 low byte decode", desc32, 1);
    acc(0, 5'h16, 0);        check("R9 mode readback 2", rv, 16'h5A02);

    // R4/R5/R6 CSR0
    acc(1, 5'h12, 0);
    acc(1, 5'h10, 16'h0001);
    check("R4 init pulse", {p_init, p_start, p_tdmd}, 3'b100);
    acc(0, 5'h10, 0);
    check("R4 pulse one cycle", {p_init, p_start, p_tdmd}, 0);
    check("R4 cmd bits read 0", rv, 16'h0004);
    acc(1, 5'h10, 16'h0000);
    check("R4 zero write no pulse", {p_init, p_start, p_tdmd}, 0);
    acc(0, 5'h10, 0, 1'b1);
    acc(0, 5'h10, 0);
    check("R6 idon set", rv, 16'h0104);
    acc(1, 5'h10, 16'h0002);
    check("R4 start pulse", {p_init, p_start, p_tdmd}, 3'b010);
    acc(0, 5'h10, 0);
    check("R5 stop cleared", rv, 16'h0100);
    acc(1, 5'h10, 16'h0008);
    check("R4 tdmd pulse", {p_init, p_start, p_tdmd}, 3'b001);
    acc(1, 5'h10, 16'h0000);
    acc(0, 5'h10, 0);
    check("R6 zero write keeps idon", rv, 16'h0100);
    acc(1, 5'h10, 16'h0100, 1'b1);
    acc(0, 5'h10, 0);
    check("R6 set wins collision", rv, 16'h0100);
    acc(1, 5'h10, 16'h0100);
    acc(0, 5'h10, 0);
    check("R6 idon cleared", rv, 16'h0000);
    acc(1, 5'h10, 16'h0004);
    acc(0, 5'h10, 0);
    check("R5 stop not writable", rv, 16'h0000);

    // R3 soft reset
    acc(1, 5'h12, 1);
    acc(0, 5'h14, 0);
    check("R3 reset read data", rv, 0);
    check("R3 eng_reset pulse", p_rst, 1);
    acc(0, 5'h12, 0);
    check("R3 eng_reset one cycle", p_rst, 0);
    check("R3 ptr kept", rv, 1);
    acc(0, 5'h10, 0);
    check("R3 ib lo cleared", rv, 0);
    check("R3 ib_addr cleared", ib_addr, 0);
    check("R3 desc32 cleared", desc32, 0);
    acc(1, 5'h12, 0);
    acc(0, 5'h10, 0);
    check("R3 csr0 after reset", rv, 16'h0004);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule